// File: doc/BRIEF.md
# Multi-Cycle Multiply-Accumulate Unit

This unit carries out the multiply and multiply-accumulate instructions of a 16-bit processor. The core presents a 16-bit instruction word with a start strobe, together with the current contents of the two registers that the instruction names. A plain multiply forms the 32-bit product of the two register values in one cycle. A multiply-accumulate treats the two register values as pointers. Over N consecutive cycles it reads one word through each pointer from a two-address combinational read port, adds the product of the pair to a cleared 32-bit accumulator, and advances both pointers by one.

The finished 32-bit value is presented as a low word and a high word. These are the values the core writes into its result register pair, registers 3 and 4. A one-cycle done strobe marks the update. The updated pointers are also exposed so the core can write them back. Each operation runs in one of two signedness modes. In the mixed mode the first factor is unsigned and the second is signed. In the other mode both factors are signed. An instruction that names a forbidden register raises a one-cycle error strobe and changes nothing.

Top module: `mac_unit`

## Requirements
- R1: After a synchronous active-low reset, `res_lo`, `res_hi`, `ptr_a` and `ptr_b` are zero, and `busy`, `done`, `err` and `rd_en` are low.
- R2: An instruction is a multiply when bits 15:12 are 4'hF, bits 8:6 are 0 or 4, and bits 5:3 equal 1. Bits 11:9 name the first register and bits 2:0 name the second. The product appears on `res_hi:res_lo`, `done` is high in the cycle after the start cycle, and `busy` stays low throughout.
- R3: Bit 8 selects the signedness mode. When it is 0, the first factor is zero-extended and the second factor is sign-extended. When it is 1, both factors are sign-extended. The result is the low 32 bits of the product.
- R4: An instruction is a multiply-accumulate when bits 15:12 are 4'hF and bit 7 is 1. Its length N equals 8 times bit 6 plus bits 5:3, and an encoded length of 0 means 16. `busy` is high for exactly N cycles, starting in the cycle after start.
- R5: A multiply-accumulate loads the pointers from `opa_val` and `opb_val`. It produces the 32-bit wrapping sum of the N products of the word pairs `mem[ptr_a+i]` and `mem[ptr_b+i]`, for i from 0 to N-1. The first factor of each product comes through `ptr_a`. The pointers finish at start+N, modulo 2^16.
- R6: When a multiply-accumulate ends, `res_lo` and `res_hi` carry the low and high halves of the sum. `done` is high for exactly one cycle, in the cycle in which `busy` has just fallen.
- R7: A multiply or multiply-accumulate that names register 0, 6 or 7 in either operand field pulses `err` for one cycle. It raises neither `done` nor `busy`, and it leaves results and pointers unchanged.
- R8: A multiply-accumulate that names register 3 or 4 in either operand field is handled as in R7. A multiply may use registers 3 and 4.
- R9: A start strobe while `busy` is high has no effect on the running operation. A start with an instruction that is neither a multiply nor a multiply-accumulate raises no strobe and changes no state.
- R10: While `busy` is high, `rd_en` is high and `rd_addr_a` and `rd_addr_b` equal the current pointers. Otherwise `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction issue strobe |
| instr | input | 16 | Instruction word |
| opa_val | input | 16 | Contents of the register in bits 11:9 |
| opb_val | input | 16 | Contents of the register in bits 2:0 |
| rd_en | output | 1 | Memory read request |
| rd_addr_a | output | 16 | Read address through the first pointer |
| rd_addr_b | output | 16 | Read address through the second pointer |
| rd_data_a | input | 16 | Word at `rd_addr_a`, same cycle |
| rd_data_b | input | 16 | Word at `rd_addr_b`, same cycle |
| res_lo | output | 16 | Low result word (register 3) |
| res_hi | output | 16 | High result word (register 4) |
| ptr_a | output | 16 | First pointer after update |
| ptr_b | output | 16 | Second pointer after update |
| busy | output | 1 | Multiply-accumulate in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle illegal-operand strobe |

## Verification
The bench runs lengths 1, 7, 8 and 16. These catch a design that folds the length bit wrongly, for example one that runs 0 or 32 steps for the 16 encoding, or 0 steps where 8 is meant. Factors of 0x8000 and 0xFFFF in both modes expose a design that sign-extends the unsigned factor or swaps the factors, because such a design returns a different high word. A pointer run that starts at 0xFFFE checks that both pointers wrap. A start issued mid-run checks that the running operation is neither restarted nor corrupted. Forbidden registers and opcodes that are not multiplies are issued between valid operations, so that any stray update of results or pointers shows at the ports.

// File: rtl/mac_pkg.sv
// mac_pkg: shared widths, instruction field positions and the decoded-instruction type
// for the multiply-accumulate unit. Assumes a fixed 16-bit instruction word.
package mac_pkg;
    localparam int INSTR_W  = 16;
    localparam int REG_SEL_W = 3;
    localparam int MAX_LEN  = 16;
    localparam int LEN_W    = $clog2(MAX_LEN + 1);
    localparam logic [3:0] SPECIAL_OP = 4'hF;

    // Registers forbidden as factors for every multiply form
    localparam logic [7:0] BAD_REG_ANY = 8'b1100_0001;
    // Additional registers forbidden while accumulating (result pair)
    localparam logic [7:0] BAD_REG_ACC = 8'b0001_1000;

    typedef struct packed {
        logic                 is_mul;
        logic                 is_mac;
        logic                 both_signed;
        logic                 legal;
        logic [LEN_W-1:0]     len;
    } mac_dec_t;
endpackage

// File: rtl/mac_decode.sv
// mac_decode: combinational instruction decoder. Classifies the word as multiply,
// multiply-accumulate or neither, extracts the signedness mode and the length
// (encoded 0 expands to MAX_LEN), and checks both operand registers against the
// forbidden sets. Assumes the caller qualifies the result with its own start strobe.
module mac_decode
    import mac_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output mac_dec_t           dec
);
    logic [3:0]           major;
    logic [REG_SEL_W-1:0] reg_a;
    logic [2:0]           sub;
    logic [2:0]           opn;
    logic [REG_SEL_W-1:0] reg_b;
    logic [3:0]           raw_len;
    logic                 bad_any;
    logic                 bad_acc;

    assign major = instr[15:12];
    assign reg_a = instr[11:9];
    assign sub   = instr[8:6];
    assign opn   = instr[5:3];
    assign reg_b = instr[2:0];

    // Classify the instruction and build the decoded record
    always_comb begin
        raw_len        = {sub[0], opn};
        bad_any        = BAD_REG_ANY[reg_a] | BAD_REG_ANY[reg_b];
        bad_acc        = BAD_REG_ACC[reg_a] | BAD_REG_ACC[reg_b];
        dec.is_mul     = (major == SPECIAL_OP) && (sub[1:0] == 2'b00) && (opn == 3'd1);
        dec.is_mac     = (major == SPECIAL_OP) && sub[1];
        dec.both_signed = sub[2];
        dec.len        = (raw_len == 4'd0) ? LEN_W'(MAX_LEN) : LEN_W'(raw_len);
        dec.legal      = !bad_any && !(dec.is_mac && bad_acc);
    end
endmodule

// File: rtl/mac_mult.sv
// mac_mult: combinational DATA_W x DATA_W multiplier with selectable signedness.
// The first factor is sign- or zero-extended per mode; the second is always signed.
// Returns the low 2*DATA_W bits of the exact product.
module mac_mult #(
    parameter int DATA_W = 16
) (
    input  logic                  both_signed,
    input  logic [DATA_W-1:0]     fa,
    input  logic [DATA_W-1:0]     fb,
    output logic [2*DATA_W-1:0]   prod
);
    localparam int EXT_W = DATA_W + 1;
    localparam int FULL_W = 2 * EXT_W;

    logic signed [EXT_W-1:0]  fa_ext;
    logic signed [EXT_W-1:0]  fb_ext;
    logic signed [FULL_W-1:0] full;

    // Extend both factors to one extra bit so a single signed multiply covers both modes
    always_comb begin
        fa_ext = both_signed ? $signed({fa[DATA_W-1], fa}) : $signed({1'b0, fa});
        fb_ext = $signed({fb[DATA_W-1], fb});
        full   = FULL_W'(fa_ext) * FULL_W'(fb_ext);
        prod   = full[2*DATA_W-1:0];
    end
endmodule

// File: rtl/mac_ctrl.sv
// mac_ctrl: sequencing for the unit. Accepts a start only when idle, raises err for
// illegal operand registers, fires a one-cycle multiply, or runs a multiply-accumulate
// of dec.len steps while stepping both pointers. Assumes combinational memory reads.
module mac_ctrl
    import mac_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mac_dec_t          dec,
    input  logic [DATA_W-1:0] opa_val,
    input  logic [DATA_W-1:0] opb_val,
    output logic              busy,
    output logic              sgn_run,
    output logic              mul_load,
    output logic              acc_clear,
    output logic              last_step,
    output logic [DATA_W-1:0] ptr_a,
    output logic [DATA_W-1:0] ptr_b,
    output logic              done,
    output logic              err
);
    logic             accept;
    logic             known;
    logic [LEN_W-1:0] steps_left;

    // Qualify the strobe: only an idle unit takes a recognised instruction
    always_comb begin
        accept    = start && !busy;
        known     = dec.is_mul || dec.is_mac;
        mul_load  = accept && dec.is_mul && dec.legal;
        acc_clear = accept && dec.is_mac && dec.legal;
        last_step = busy && (steps_left == LEN_W'(1));
    end

    // Run state, step counter, pointers and the two strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            sgn_run    <= 1'b0;
            steps_left <= '0;
            ptr_a      <= '0;
            ptr_b      <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (accept && known) begin
                if (!dec.legal) begin
                    err <= 1'b1;
                end else if (dec.is_mul) begin
                    done <= 1'b1;
                end else begin
                    busy       <= 1'b1;
                    sgn_run    <= dec.both_signed;
                    steps_left <= dec.len;
                    ptr_a      <= opa_val;
                    ptr_b      <= opb_val;
                end
            end else if (busy) begin
                ptr_a      <= ptr_a + DATA_W'(1);
                ptr_b      <= ptr_b + DATA_W'(1);
                steps_left <= steps_left - LEN_W'(1);
                if (last_step) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mac_accum.sv
// mac_accum: accumulator and result-pair register. A multiply loads the product
// directly; an accumulate run clears, sums each step, and on the final step writes
// accumulator plus the last product into the result pair. Sums wrap at 2*DATA_W bits.
module mac_accum #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mul_load,
    input  logic                acc_clear,
    input  logic                step,
    input  logic                last_step,
    input  logic [2*DATA_W-1:0] prod,
    output logic [DATA_W-1:0]   res_lo,
    output logic [DATA_W-1:0]   res_hi
);
    localparam int ACC_W = 2 * DATA_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_next;

    // Running sum including this cycle's product
    always_comb acc_next = acc + prod;

    // Accumulator update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (acc_clear) begin
            acc <= '0;
        end else if (step) begin
            acc <= acc_next;
        end
    end

    // Result pair update on multiply or on the last accumulate step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (mul_load) begin
            res_lo <= prod[DATA_W-1:0];
            res_hi <= prod[ACC_W-1:DATA_W];
        end else if (last_step) begin
            res_lo <= acc_next[DATA_W-1:0];
            res_hi <= acc_next[ACC_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/mac_unit.sv
// mac_unit: top of the multiply / multiply-accumulate unit. Decodes the instruction,
// shares one multiplier between register factors (multiply) and memory factors
// (accumulate run), and exposes results, pointers and strobes. Assumes the memory
// port returns data in the same cycle as the address.
module mac_unit #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic [DATA_W-1:0] opa_val,
    input  logic [DATA_W-1:0] opb_val,
    output logic              rd_en,
    output logic [DATA_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_addr_b,
    input  logic [DATA_W-1:0] rd_data_a,
    input  logic [DATA_W-1:0] rd_data_b,
    output logic [DATA_W-1:0] res_lo,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] ptr_a,
    output logic [DATA_W-1:0] ptr_b,
    output logic              busy,
    output logic              done,
    output logic              err
);
    import mac_pkg::*;

    mac_dec_t            dec;
    logic                sgn_run;
    logic                mul_load;
    logic                acc_clear;
    logic                last_step;
    logic                mode_sel;
    logic [DATA_W-1:0]   fac_a;
    logic [DATA_W-1:0]   fac_b;
    logic [2*DATA_W-1:0] prod;

    mac_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    mac_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dec       (dec),
        .opa_val   (opa_val),
        .opb_val   (opb_val),
        .busy      (busy),
        .sgn_run   (sgn_run),
        .mul_load  (mul_load),
        .acc_clear (acc_clear),
        .last_step (last_step),
        .ptr_a     (ptr_a),
        .ptr_b     (ptr_b),
        .done      (done),
        .err       (err)
    );

    // Factor and mode steering: memory words while running, register values otherwise
    always_comb begin
        fac_a    = busy ? rd_data_a : opa_val;
        fac_b    = busy ? rd_data_b : opb_val;
        mode_sel = busy ? sgn_run : dec.both_signed;
    end

    mac_mult #(.DATA_W(DATA_W)) u_mult (
        .both_signed (mode_sel),
        .fa          (fac_a),
        .fb          (fac_b),
        .prod        (prod)
    );

    mac_accum #(.DATA_W(DATA_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mul_load  (mul_load),
        .acc_clear (acc_clear),
        .step      (busy),
        .last_step (last_step),
        .prod      (prod),
        .res_lo    (res_lo),
        .res_hi    (res_hi)
    );

    // Memory port mirrors the live pointers during a run
    always_comb begin
        rd_en     = busy;
        rd_addr_a = ptr_a;
        rd_addr_b = ptr_b;
    end
endmodule

// File: rtl/mac_unit_chk.sv
// mac_unit_chk: protocol checks on the unit's ports, bound into every mac_unit.
module mac_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] res_lo,
    input logic [DATA_W-1:0] res_hi,
    input logic [DATA_W-1:0] ptr_a,
    input logic [DATA_W-1:0] ptr_b,
    input logic              busy,
    input logic              done,
    input logic              err
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R6
    AST_PTR_STEP_A: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ptr_a == $past(ptr_a) + DATA_W'(1)); // R5
    AST_PTR_STEP_B: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ptr_b == $past(ptr_b) + DATA_W'(1)); // R5
    AST_ERR_KEEPS_RES: assert property (@(posedge clk) disable iff (!rst_n) err |-> $stable(res_lo) && $stable(res_hi)); // R7
    AST_ERR_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n) err |-> $stable(ptr_a) && $stable(ptr_b)); // R7
    AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n) err |-> !done && !busy); // R7
    AST_RD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> busy && rd_addr_a == ptr_a); // R10
endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr_a (rd_addr_a),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .ptr_a     (ptr_a),
    .ptr_b     (ptr_b),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] opa_val = '0;
    logic [15:0] opb_val = '0;
    logic        rd_en;
    logic [15:0] rd_addr_a, rd_addr_b, rd_data_a, rd_data_b;
    logic [15:0] res_lo, res_hi, ptr_a, ptr_b;
    logic        busy, done, err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        logic [31:0] t;
        t = a * 32'd40503 + 32'd12345;
        return t[15:0] ^ {3'b0, a[15:3]} ^ t[31:16];
    endfunction

    assign rd_data_a = memf(rd_addr_a);
    assign rd_data_b = memf(rd_addr_b);

    mac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .opa_val(opa_val), .opb_val(opb_val), .rd_en(rd_en),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .res_lo(res_lo), .res_hi(res_hi), .ptr_a(ptr_a), .ptr_b(ptr_b),
        .busy(busy), .done(done), .err(err)
    );

    function automatic logic [31:0] mulx(input bit sgn, input logic [15:0] a, input logic [15:0] b);
        longint sa, sb;
        sa = sgn ? longint'($signed(a)) : longint'(a);
        sb = longint'($signed(b));
        return 32'(sa * sb);
    endfunction

    function automatic logic [15:0] enc_mul(input bit sgn, input logic [2:0] ra, input logic [2:0] rb);
        return {4'hF, ra, sgn, 2'b00, 3'd1, rb};
    endfunction

    function automatic logic [15:0] enc_mac(input bit sgn, input int n, input logic [2:0] ra, input logic [2:0] rb);
        logic [4:0] nn;
        nn = 5'(n);
        return {4'hF, ra, sgn, 1'b1, nn[3], nn[2:0], rb};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_mul(input bit sgn, input logic [2:0] ra, input logic [2:0] rb,
                           input logic [15:0] va, input logic [15:0] vb);
        logic [15:0] pa0, pb0;
        pa0 = ptr_a; pb0 = ptr_b;
        @(negedge clk);
        instr = enc_mul(sgn, ra, rb); opa_val = va; opb_val = vb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 done", 32'(done), 32'd1);
        chk("R2 busy low", 32'(busy), 32'd0);
        chk("R3 product", {res_hi, res_lo}, mulx(sgn, va, vb));
        chk("R2 ptrs kept", {ptr_a, ptr_b}, {pa0, pb0});
        @(negedge clk);
        chk("R6 done pulse", 32'(done), 32'd0);
    endtask

    task automatic run_mac(input bit sgn, input int n, input logic [2:0] ra, input logic [2:0] rb,
                           input logic [15:0] pa, input logic [15:0] pb, input bit inject);
        logic [31:0] sum;
        int cyc;
        sum = '0;
        for (int i = 0; i < n; i++)
            sum += mulx(sgn, memf(16'(pa + 16'(i))), memf(16'(pb + 16'(i))));
        @(negedge clk);
        instr = enc_mac(sgn, n, ra, rb); opa_val = pa; opb_val = pb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 40) begin
            chk("R10 rd port", {15'b0, rd_en, rd_addr_a, rd_addr_b} ,
                {15'b0, 1'b1, 16'(pa + 16'(cyc)), 16'(pb + 16'(cyc))});
            if (inject && cyc == 1) begin
                instr = enc_mac(!sgn, 3, 3'd5, 3'd1); opa_val = 16'h1234; opb_val = 16'h4321; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(inject ? "R9 busy length with mid-run start" : "R4 busy length", 32'(cyc), 32'(n));
        chk("R6 done at end", 32'(done), 32'd1);
        chk("R5 sum", {res_hi, res_lo}, sum);
        chk("R5 final ptrs", {ptr_a, ptr_b}, {16'(pa + 16'(n)), 16'(pb + 16'(n))});
        chk("R10 rd_en low", 32'(rd_en), 32'd0);
        @(negedge clk);
        chk("R6 done pulse", 32'(done), 32'd0);
    endtask

    task automatic run_bad(input logic [15:0] word, input bit expect_err, input string req);
        logic [31:0] r0, p0;
        r0 = {res_hi, res_lo}; p0 = {ptr_a, ptr_b};
        @(negedge clk);
        instr = word; opa_val = 16'hBEEF; opb_val = 16'h0F0F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " err"}, 32'(err), 32'(expect_err));
        chk({req, " no done/busy"}, {30'b0, done, busy}, 32'd0);
        chk({req, " result kept"}, {res_hi, res_lo}, r0);
        chk({req, " ptrs kept"}, {ptr_a, ptr_b}, p0);
        @(negedge clk);
        chk({req, " err pulse"}, 32'(err), 32'd0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] mul_regs [5];
        logic [2:0] mac_regs [3];
        int seed;
        mul_regs = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
        mac_regs = '{3'd1, 3'd2, 3'd5};
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {res_hi, res_lo}, 32'd0);
        chk("R1 reset ptrs", {ptr_a, ptr_b}, 32'd0);
        chk("R1 reset strobes", {28'b0, busy, done, err, rd_en}, 32'd0);

        // Directed multiply corners, R2 and R3 in both modes
        run_mul(1'b0, 3'd1, 3'd2, 16'hFFFF, 16'h8000);
        run_mul(1'b1, 3'd1, 3'd2, 16'hFFFF, 16'h8000);
        run_mul(1'b1, 3'd3, 3'd4, 16'h8000, 16'h8000);
        run_mul(1'b0, 3'd5, 3'd3, 16'h8000, 16'h7FFF);
        // Directed accumulate lengths: R4 folding incl. 16 encoded as zero
        run_mac(1'b0, 1, 3'd1, 3'd2, 16'h0100, 16'h0200, 1'b0);
        run_mac(1'b1, 7, 3'd2, 3'd5, 16'h1000, 16'h2000, 1'b0);
        run_mac(1'b0, 8, 3'd5, 3'd1, 16'h3000, 16'h3100, 1'b0);
        run_mac(1'b1, 16, 3'd1, 3'd5, 16'h4000, 16'h8123, 1'b0);
        // R5 pointer wrap
        run_mac(1'b1, 4, 3'd1, 3'd2, 16'hFFFE, 16'hFFFF, 1'b0);
        // R9 start while busy is ignored
        run_mac(1'b0, 6, 3'd2, 3'd1, 16'h0500, 16'h0A00, 1'b1);
        // R7 forbidden registers in multiply
        run_bad(enc_mul(1'b0, 3'd0, 3'd2), 1'b1, "R7 mul reg0");
        run_bad(enc_mul(1'b1, 3'd1, 3'd6), 1'b1, "R7 mul reg6");
        run_bad(enc_mac(1'b0, 5, 3'd7, 3'd1), 1'b1, "R7 mac reg7");
        // R8 result registers in accumulate
        run_bad(enc_mac(1'b1, 3, 3'd3, 3'd1), 1'b1, "R8 mac reg3");
        run_bad(enc_mac(1'b0, 16, 3'd2, 3'd4), 1'b1, "R8 mac reg4");
        // R9 unrelated instructions
        run_bad(16'h0A4B, 1'b0, "R9 non-special op");
        run_bad({4'hF, 3'd1, 3'd0, 3'd2, 3'd2}, 1'b0, "R9 F-op not multiply");

        // Constrained random mix
        for (int k = 0; k < 30; k++) begin
            if ($urandom_range(0, 2) != 0) begin
                run_mul(1'($urandom_range(0, 1)), mul_regs[$urandom_range(0, 4)],
                        mul_regs[$urandom_range(0, 4)], 16'($urandom), 16'($urandom));
            end else begin
                run_mac(1'($urandom_range(0, 1)), int'($urandom_range(1, 16)),
                        mac_regs[$urandom_range(0, 2)], mac_regs[$urandom_range(0, 2)],
                        16'($urandom), 16'($urandom), 1'b0);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule